// File: doc/BRIEF.md
# Time-Shared Twenty-Tap FIR Filter

This block computes a 20-tap finite impulse response on a stream of signed samples while using only four multipliers. The internal clock runs at least five times faster than the sample rate; each accepted sample launches a five-phase burst. During the burst, four multiply-add stages connected as an adder chain each work through five taps. A fifth unit then folds the partial sums into the final result. Stage k keeps its own five-sample history and five coefficients. It reads both at a phase address that trails stage k-1 by one register. Its shift strobe trails by one register in the same way.

A controller state machine has two named states. `CTL_IDLE` waits for a sample. `CTL_RUN` steps a phase counter from 0 to 4. The transitions are: *start* (IDLE to RUN on `in_valid`), *step* (RUN to RUN while the count is below 4), *chain* (RUN to RUN with the counter back at 0 when a sample arrives on phase 4), and *finish* (RUN to IDLE on phase 4 with no sample). The output accumulator has two operating modes, `OP_LOAD` and `OP_ADD`. It uses `OP_LOAD` for exactly one cycle per result, so the previous total never needs a separate clear. A capture register presents the completed sum with a one-cycle `out_valid`.

Top module: `fir_sp_top`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `out_data` are 0. All sample history is zero after reset.
- R2: For accepted samples x[n] (signed, `DATA_W` bits), each result is y[n] = sum over i = 0..19 of h[i]·x[n-i], with h[i] = ((37·i + 11) mod 401) − 200. The result is full-precision signed in `SUM_W` bits.
- R3: A sample accepted at clock edge E produces `out_valid` high for exactly one cycle, registered at edge E+9.
- R4: A new sample may be accepted on the last phase of the previous burst, so samples may arrive every 5 cycles indefinitely.
- R5: `in_valid` during the first four phases of a burst (counter 0 to 3) is ignored. It does not shift the history, restart the counter or create an output.
- R6: Idle time of any length between samples keeps the history intact.
- R7: Full-scale inputs (−2048 and +2047 for 12-bit data) produce exact results without overflow.
- R8: Exactly one output is produced per accepted sample, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock, at least 5× the sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | SUM_W | Signed filter result |

## Verification
The tightest case is a sample arriving on phase 4 of the previous burst. In that cycle the controller wraps its counter while accepting the sample, and stage 0 reads its oldest entry just before that entry is shifted out. The bench provokes this with samples spaced exactly five cycles apart. It judges the result by comparing every output value against a direct convolution and every output's arrival cycle against nine edges after acceptance. Pulses placed on phases 0 to 3 check that mid-burst strobes leave both the results and their timing unchanged.

// File: rtl/fir_sp_pkg.sv
package fir_sp_pkg;

    typedef enum logic {
        CTL_IDLE,
        CTL_RUN
    } ctl_state_e;

    typedef enum logic {
        OP_LOAD,
        OP_ADD
    } acc_op_e;

    // Tap weight for absolute tap index idx (0 = newest sample).
    function automatic int tap_coef(input int idx);
        return ((idx * 37 + 11) % 401) - 200;
    endfunction

endpackage

// File: rtl/fir_sp_ctrl.sv
module fir_sp_ctrl
    import fir_sp_pkg::*;
#(
    parameter int PHASES = 5,
    parameter int STAGES = 4,
    localparam int PH_W = $clog2(PHASES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    output logic                          accept_o,
    output logic                          busy_o,
    output logic [PH_W-1:0]               cnt_o,
    output logic [STAGES-1:0][PH_W-1:0]   addr_o,
    output logic [STAGES-1:0]             shift_o,
    output logic                          first_o,
    output logic                          last_o
);

    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);

    ctl_state_e state_q, state_d;
    logic [PH_W-1:0] cnt_q, cnt_d;
    logic at_last;

    logic [STAGES:0] first_d;
    logic [STAGES:0] last_d;

    always_comb begin
        at_last  = (state_q == CTL_RUN) && (cnt_q == PH_LAST);
        accept_o = in_valid && ((state_q == CTL_IDLE) || at_last);
        state_d  = state_q;
        cnt_d    = cnt_q;
        unique case (state_q)
            CTL_IDLE: begin
                if (accept_o) begin        // start
                    state_d = CTL_RUN;
                    cnt_d   = '0;
                end
            end
            CTL_RUN: begin
                if (cnt_q != PH_LAST) begin        // step
                    cnt_d = cnt_q + 1'b1;
                end else if (accept_o) begin       // chain
                    cnt_d = '0;
                end else begin                     // finish
                    state_d = CTL_IDLE;
                end
            end
            default: state_d = CTL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CTL_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        busy_o     = (state_q == CTL_RUN);
        cnt_o      = cnt_q;
        first_d[0] = busy_o && (cnt_q == '0);
        last_d[0]  = at_last;
        addr_o[0]  = cnt_q;
        shift_o[0] = accept_o;
        first_o    = first_d[STAGES];
        last_o     = last_d[STAGES];
    end

    // Each later stage sees the address and shift strobe one register later.
    for (genvar k = 1; k < STAGES; k++) begin : g_stage_dly
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_o[k]  <= '0;
                shift_o[k] <= 1'b0;
            end else begin
                addr_o[k]  <= addr_o[k-1];
                shift_o[k] <= shift_o[k-1];
            end
        end
    end

    // Burst boundary flags travel the length of the chain to the accumulator.
    for (genvar k = 1; k <= STAGES; k++) begin : g_flag_dly
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                first_d[k] <= 1'b0;
                last_d[k]  <= 1'b0;
            end else begin
                first_d[k] <= first_d[k-1];
                last_d[k]  <= last_d[k-1];
            end
        end
    end

endmodule

// File: rtl/fir_sp_stage.sv
module fir_sp_stage
    import fir_sp_pkg::*;
#(
    parameter int STAGE_IDX = 0,
    parameter int PHASES    = 5,
    parameter int DATA_W    = 12,
    parameter int COEF_W    = 10,
    parameter int SUM_W     = 27,
    localparam int PH_W     = $clog2(PHASES),
    localparam int PROD_W   = DATA_W + COEF_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     shift_i,
    input  logic [PH_W-1:0]          addr_i,
    input  logic signed [DATA_W-1:0] smp_i,
    output logic signed [DATA_W-1:0] spill_o,
    input  logic signed [SUM_W-1:0]  psum_i,
    output logic signed [SUM_W-1:0]  psum_o
);

    logic signed [DATA_W-1:0] hist_q [PHASES];
    logic signed [DATA_W-1:0] rd_smp;
    logic signed [COEF_W-1:0] coef;
    logic signed [PROD_W-1:0] prod;

    // History: entry i holds the sample i positions older than the newest one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PHASES; i++) hist_q[i] <= '0;
            spill_o <= '0;
        end else if (shift_i) begin
            hist_q[0] <= smp_i;
            for (int i = 1; i < PHASES; i++) hist_q[i] <= hist_q[i-1];
            spill_o <= hist_q[PHASES-1];
        end
    end

    always_comb begin
        rd_smp = hist_q[addr_i];
        coef   = COEF_W'(tap_coef(STAGE_IDX * PHASES + int'(addr_i)));
        prod   = rd_smp * coef;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) psum_o <= '0;
        else        psum_o <= psum_i + SUM_W'(prod);
    end

endmodule

// File: rtl/fir_sp_accum.sv
module fir_sp_accum
    import fir_sp_pkg::*;
#(
    parameter int SUM_W = 27
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    first_i,
    input  logic                    last_i,
    input  logic signed [SUM_W-1:0] psum_i,
    output logic                    out_valid_o,
    output logic signed [SUM_W-1:0] out_data_o
);

    acc_op_e op;
    logic signed [SUM_W-1:0] acc_q, acc_d;

    always_comb begin
        op = first_i ? OP_LOAD : OP_ADD;
        unique case (op)
            OP_LOAD: acc_d = psum_i;
            OP_ADD:  acc_d = acc_q + psum_i;
            default: acc_d = psum_i;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q       <= '0;
            out_valid_o <= 1'b0;
            out_data_o  <= '0;
        end else begin
            acc_q       <= acc_d;
            out_valid_o <= last_i;
            if (last_i) out_data_o <= acc_d;
        end
    end

endmodule

// File: rtl/fir_sp_top.sv
module fir_sp_top
    import fir_sp_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int COEF_W = 10,
    parameter int TAPS   = 20,
    parameter int STAGES = 4,
    localparam int PHASES = TAPS / STAGES,
    localparam int PH_W   = $clog2(PHASES),
    localparam int SUM_W  = DATA_W + COEF_W + $clog2(TAPS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     out_valid,
    output logic signed [SUM_W-1:0]  out_data
);

    logic                        accept;
    logic                        ctl_busy;
    logic [PH_W-1:0]             ctl_cnt;
    logic [STAGES-1:0][PH_W-1:0] stg_addr;
    logic [STAGES-1:0]           stg_shift;
    logic                        acc_first;
    logic                        acc_last;

    logic signed [DATA_W-1:0] smp_chain [STAGES+1];
    logic signed [SUM_W-1:0]  sum_chain [STAGES+1];

    assign smp_chain[0] = in_data;
    assign sum_chain[0] = '0;

    fir_sp_ctrl #(.PHASES(PHASES), .STAGES(STAGES)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .accept_o (accept),
        .busy_o   (ctl_busy),
        .cnt_o    (ctl_cnt),
        .addr_o   (stg_addr),
        .shift_o  (stg_shift),
        .first_o  (acc_first),
        .last_o   (acc_last)
    );

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        fir_sp_stage #(
            .STAGE_IDX (k),
            .PHASES    (PHASES),
            .DATA_W    (DATA_W),
            .COEF_W    (COEF_W),
            .SUM_W     (SUM_W)
        ) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .shift_i (stg_shift[k]),
            .addr_i  (stg_addr[k]),
            .smp_i   (smp_chain[k]),
            .spill_o (smp_chain[k+1]),
            .psum_i  (sum_chain[k]),
            .psum_o  (sum_chain[k+1])
        );
    end

    fir_sp_accum #(.SUM_W(SUM_W)) u_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .first_i     (acc_first),
        .last_i      (acc_last),
        .psum_i      (sum_chain[STAGES]),
        .out_valid_o (out_valid),
        .out_data_o  (out_data)
    );

endmodule

// File: rtl/fir_sp_chk.sv
module fir_sp_chk #(
    parameter int PHASES = 5,
    localparam int PH_W  = $clog2(PHASES)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            accept,
    input logic            busy,
    input logic [PH_W-1:0] cnt,
    input logic            out_valid
);

    localparam int GAP_W = $clog2(PHASES) + 1;

    logic [2:0]       pending;
    logic [GAP_W-1:0] gap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= '0;
            gap     <= GAP_W'(PHASES);
        end else begin
            pending <= pending + 3'(accept) - 3'(out_valid);
            if (accept)                  gap <= '0;
            else if (gap != GAP_W'(PHASES)) gap <= gap + 1'b1;
        end
    end

    // R3: result strobe lasts a single cycle
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R4: accepted samples are at least one burst apart
    a_r4_accept_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (gap >= GAP_W'(PHASES - 1)));

    // R5: a mid-burst strobe does not restart the phase counter
    a_r5_mid_burst_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && busy && (cnt != PH_W'(PHASES - 1))) |=> (cnt == PH_W'($past(cnt) + 1'b1)));

    // R8: no result without an accepted sample
    a_r8_output_owed: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (pending != '0));

    // R8: at most two samples in flight
    a_r8_pending_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pending <= 3'd2);

endmodule

bind fir_sp_top fir_sp_chk #(.PHASES(PHASES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .accept    (accept),
    .busy      (ctl_busy),
    .cnt       (ctl_cnt),
    .out_valid (out_valid)
);

// File: tb/fir_sp_top_tb.sv
`timescale 1ns/1ps
module fir_sp_top_tb;

    localparam int DATA_W  = 12;
    localparam int SUM_W   = 27;
    localparam int NTAP    = 20;
    localparam int LATENCY = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [DATA_W-1:0] in_data = '0;
    logic out_valid;
    logic signed [SUM_W-1:0] out_data;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int sent = 0;
    int got = 0;
    bit done = 1'b0;
    string cur_req = "R2";
    int unsigned seed = 32'h1234_5678;

    longint hist [NTAP];
    longint exp_q [$];
    int     stamp_q [$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fir_sp_top u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic longint h_of(input int i);
        return longint'(((i * 37 + 11) % 401) - 200);
    endfunction

    function automatic logic signed [DATA_W-1:0] next_val();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed[27:16];
    endfunction

    task automatic check(input string req, input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // Driver: updates the reference model and pushes the expected result.
    task automatic push_model(input logic signed [DATA_W-1:0] x);
        longint acc = 0;
        for (int i = NTAP - 1; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = longint'(x);
        for (int i = 0; i < NTAP; i++) acc += h_of(i) * hist[i];
        exp_q.push_back(acc);
        stamp_q.push_back(cyc + 1 + LATENCY);
        sent++;
    endtask

    task automatic send(input logic signed [DATA_W-1:0] x, input int spacing);
        in_valid = 1'b1;
        in_data  = x;
        push_model(x);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (spacing - 1) @(negedge clk);
    endtask

    // Sample plus an ignored strobe "off" cycles later, within the same burst.
    task automatic send_poke(input logic signed [DATA_W-1:0] x, input int off);
        in_valid = 1'b1;
        in_data  = x;
        push_model(x);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (off - 1) @(negedge clk);
        in_valid = 1'b1;
        in_data  = next_val();
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4 - off) @(negedge clk);
    endtask

    // Monitor: pops the scoreboard as results appear.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            got++;
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R8 actual=unexpected output %0d expected=none", out_data);
            end else begin
                check(cur_req, longint'(out_data), exp_q.pop_front());
                check("R3", longint'(cyc), longint'(stamp_q.pop_front()));
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < NTAP; i++) hist[i] = 0;
        repeat (3) @(negedge clk);
        // R1: outputs idle in reset
        check("R1", longint'(out_valid), 0);
        check("R1", longint'(out_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", longint'(out_valid), 0);

        // R2: impulse response reproduces every tap weight
        cur_req = "R2";
        send(12'sd1000, 7);
        for (int i = 0; i < NTAP + 2; i++) send(12'sd0, 6);
        for (int i = 0; i < 10; i++) send(12'sd1, 8);

        // R4: sustained one sample every five cycles
        cur_req = "R4";
        for (int i = 0; i < 40; i++) send(next_val(), 5);

        // R6: long and varied idle gaps
        cur_req = "R6";
        for (int i = 0; i < 25; i++) send(next_val(), 5 + (i * 7) % 31);

        // R5: strobes on phases 0..3 are ignored
        cur_req = "R5";
        for (int i = 0; i < 24; i++) send_poke(next_val(), 1 + i % 4);
        repeat (20) @(negedge clk);
        check("R5", longint'(got), longint'(sent));

        // R7: full-scale values
        cur_req = "R7";
        for (int i = 0; i < NTAP + 3; i++) send(-12'sd2048, 5);
        for (int i = 0; i < NTAP + 3; i++) send(12'sd2047, 5);
        for (int i = 0; i < NTAP; i++) send((i % 2 == 0) ? -12'sd2048 : 12'sd2047, 5);

        repeat (30) @(negedge clk);
        // R8: every accepted sample produced exactly one result
        check("R8", longint'(exp_q.size()), 0);
        check("R8", longint'(got), longint'(sent));
        finish_run();
    end

endmodule